// File: doc/BRIEF.md
# Configurable Parallel Bus Master

This block runs single read and write transfers on an external 8-bit parallel bus for an internal register interface. Software selects how the address reaches the bus: both address bytes time-shared on the data lines, only the low byte time-shared with the upper bits on dedicated pins, or every bit on dedicated pins. It also selects one of two strobe styles, the active level of each control output, three wait-state fields and what happens to the address once a transfer has finished.

A transfer starts from a one-cycle request. The sequencer then steps through the latch phases, a bus turnaround cycle for reads, the data strobe and the data hold. It drives the chip select, the latch strobes, the read, write and enable strobes and the output enable of the shared data bus. Read data is captured into a holding register, and a done flag rises when the read ends. The configuration inputs are assumed to stay stable while a transfer is in progress.

Top module: `pbus_master`

## Requirements
- R1: After a synchronous reset `busy`, `rd_done` and `bus_oe` are 0, the address is 0, and every control pin sits at its inactive level (the inverse of its `cfg_pol` bit). Whenever `busy` is 0, all control pins are inactive and `bus_oe` is 0.
- R2: With `cfg_amode`=0 (both bytes multiplexed), a transfer begins with the low latch strobe active for 1+`cfg_wait_setup` cycles while the bus drives address bits [7:0]. The high latch strobe then follows for the same number of cycles while the bus drives address bits [ADDR_W-1:8], zero-extended. `bus_oe` is 1 in both phases, and the two latch strobes are never active together.
- R3: With `cfg_amode`=1 (low byte multiplexed), only the low latch phase occurs and the high latch strobe stays inactive. During the transfer `addr_pins` carries address bits [ADDR_W-1:8] in its upper bits and zeros in bits [7:0].
- R4: With `cfg_amode`=2 or 3 (no multiplexing), no latch phase occurs and `addr_pins` carries the address. When `cfg_use_cs`=1, the top address pin is driven 0. When `cfg_use_cs`=0, that pin carries the top address bit and the chip select stays inactive. In this mode `addr_pins` shows the address even while idle.
- R5: With `cfg_use_cs`=1, the chip select is active in every cycle in which `busy` is 1.
- R6: With `cfg_strobe`=0 (separate strobes), the read strobe (reads) or the write strobe (writes) is active for 1+`cfg_wait_strobe` cycles and the two are never active together. With `cfg_strobe`=1, `rd_pin` is a direction line that is active for the whole of a read's busy time, `wr_pin` stays inactive, and `en_pin` is the strobe, active for 1+`cfg_wait_strobe` cycles.
- R7: Each bit of `cfg_pol` sets the active level of one control output (1 = active high): [0] chip select, [1] read/direction, [2] write, [3] enable, [4] low latch, [5] high latch.
- R8: `busy` lasts L·(1+`cfg_wait_setup`) + T + (1+`cfg_wait_strobe`) + (1+`cfg_wait_hold`) cycles. L is 2, 1 or 0 latch phases for modes 0, 1 and 2, and T is 1 for a read and 0 for a write.
- R9: `bus_oe` is 1 only in the latch phases and in the strobe and hold phases of a write, when the bus carries the write data. During a read the data strobe is never active while `bus_oe` is 1, and `bus_oe` is 0 in the cycle before the read strobe first becomes active.
- R10: `bus_in` is sampled in the last cycle of a read's strobe phase into `rd_data`. `rd_done` rises when that read's `busy` falls, and it is cleared when the next transfer starts.
- R11: When a transfer ends, the address holds for `cfg_auto` = 0 or 3, increments by one for 1, and decrements by one for 2, wrapping modulo 2^ADDR_W. `addr_ld` loads `addr_ld_val` while the block is idle.
- R12: `start_rd`, `start_wr` and `addr_ld` are ignored while `busy` is 1. If `start_rd` and `start_wr` arrive in the same idle cycle, a read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_amode | input | 2 | Address mode: 0 both bytes multiplexed, 1 low byte multiplexed, 2/3 dedicated pins |
| cfg_strobe | input | 1 | 0 separate read/write strobes, 1 direction line plus enable |
| cfg_pol | input | 6 | Active-high select per control output |
| cfg_auto | input | 2 | Address step after a transfer: 0/3 hold, 1 up, 2 down |
| cfg_use_cs | input | 1 | Use the chip select (otherwise the top address pin carries address) |
| cfg_wait_setup | input | 2 | Extra cycles per latch phase |
| cfg_wait_strobe | input | 2 | Extra strobe cycles |
| cfg_wait_hold | input | 2 | Extra hold cycles |
| addr_ld | input | 1 | Load the address register |
| addr_ld_val | input | ADDR_W | Value to load |
| start_rd | input | 1 | Start a read |
| start_wr | input | 1 | Start a write |
| wdata | input | 8 | Write data, taken with `start_wr` |
| busy | output | 1 | Transfer in progress |
| rd_data | output | 8 | Read holding register |
| rd_done | output | 1 | Read completed |
| bus_in | input | 8 | Data bus input from the pads |
| bus_out | output | 8 | Data bus output to the pads |
| bus_oe | output | 1 | Data bus output enable |
| addr_pins | output | ADDR_W | Dedicated address pins |
| cs_pin | output | 1 | Chip select |
| rd_pin | output | 1 | Read strobe or direction line |
| wr_pin | output | 1 | Write strobe |
| en_pin | output | 1 | Enable strobe |
| alo_pin | output | 1 | Low address latch strobe |
| ahi_pin | output | 1 | High address latch strobe |

## Verification
The bench runs four kinds of transfer. The first is a read with both address bytes multiplexed and a nonzero value in every wait field. The second is a write with only the low byte multiplexed. The third is a read with dedicated address pins and the direction/enable strobe style at active-high polarity, and the fourth is a write without the chip select. Counting each pin's active cycles separates the three address modes and the two strobe styles, and a wrong wait field shows up as a wrong phase length. Checking the bus contents during each latch and strobe phase shows that the address bytes, the write data and the read sample land in the right phase. The address is stepped up, stepped down, wrapped from the top value and held. Requests made while busy, and simultaneous read and write requests, show whether the ignore rule and the read priority are honoured.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    localparam int BYTE_W = 8;
    localparam int WAIT_W = 2;
    localparam int NCTL   = 6;

    // control vector bit positions, shared with cfg_pol
    localparam int C_CS  = 0;
    localparam int C_RD  = 1;
    localparam int C_WR  = 2;
    localparam int C_EN  = 3;
    localparam int C_ALO = 4;
    localparam int C_AHI = 5;

    localparam logic [1:0] AM_FULL = 2'd0;
    localparam logic [1:0] AM_PART = 2'd1;

    localparam logic [1:0] AUTO_INC = 2'd1;
    localparam logic [1:0] AUTO_DEC = 2'd2;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ALO, PH_AHI, PH_TURN, PH_STB, PH_HOLD
    } phase_e;

    function automatic logic [NCTL-1:0] to_level(input logic [NCTL-1:0] act,
                                                 input logic [NCTL-1:0] pol);
        return ~(act ^ pol);
    endfunction
endpackage

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go_rd,
    input  logic              go_wr,
    input  logic [1:0]        amode,
    input  logic [WAIT_W-1:0] w_setup,
    input  logic [WAIT_W-1:0] w_strb,
    input  logic [WAIT_W-1:0] w_hold,
    output phase_e            phase,
    output logic              is_read,
    output logic              strb_end,
    output logic              txn_end
);
    logic [WAIT_W-1:0] cnt, limit;
    phase_e            nxt, first, after_addr;
    logic              ph_end, muxed;

    assign muxed      = (amode == AM_FULL) || (amode == AM_PART);
    assign first      = muxed ? PH_ALO : (go_rd ? PH_TURN : PH_STB);
    assign after_addr = is_read ? PH_TURN : PH_STB;

    always_comb begin
        case (phase)
            PH_ALO, PH_AHI: limit = w_setup;
            PH_STB:         limit = w_strb;
            PH_HOLD:        limit = w_hold;
            default:        limit = '0;
        endcase
    end

    assign ph_end = (cnt == limit);

    always_comb begin
        case (phase)
            PH_IDLE: nxt = first;
            PH_ALO:  nxt = (amode == AM_FULL) ? PH_AHI : after_addr;
            PH_AHI:  nxt = after_addr;
            PH_TURN: nxt = PH_STB;
            PH_STB:  nxt = PH_HOLD;
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            is_read <= 1'b0;
        end else if (phase == PH_IDLE) begin
            cnt <= '0;
            if (go_rd || go_wr) begin
                phase   <= nxt;
                is_read <= go_rd;
            end
        end else if (ph_end) begin
            phase <= nxt;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign strb_end = (phase == PH_STB) && ph_end;
    assign txn_end  = (phase == PH_HOLD) && ph_end;
endmodule

// File: rtl/pbus_addr.sv
module pbus_addr
    import pbus_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idle,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              txn_end,
    input  logic [1:0]        auto_mode,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (idle && ld) begin
            addr <= ld_val;
        end else if (txn_end) begin
            if (auto_mode == AUTO_INC)      addr <= addr + 1'b1;
            else if (auto_mode == AUTO_DEC) addr <= addr - 1'b1;
        end
    end
endmodule

// File: rtl/pbus_pins.sv
module pbus_pins
    import pbus_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  phase_e            phase,
    input  logic              is_read,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_q,
    input  logic [1:0]        amode,
    input  logic              strobe_style,
    input  logic              use_cs,
    input  logic [NCTL-1:0]   pol,
    output logic [BYTE_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] addr_pins,
    output logic [NCTL-1:0]   ctl_lvl
);
    localparam int HI_W = ADDR_W - BYTE_W;

    logic            busy, in_stb, wr_data;
    logic [NCTL-1:0] act;

    assign busy    = (phase != PH_IDLE);
    assign in_stb  = (phase == PH_STB);
    assign wr_data = !is_read && (in_stb || phase == PH_HOLD);

    always_comb begin
        act        = '0;
        act[C_CS]  = busy && use_cs;
        act[C_ALO] = (phase == PH_ALO);
        act[C_AHI] = (phase == PH_AHI);
        if (strobe_style) begin
            act[C_RD] = busy && is_read;
            act[C_EN] = in_stb;
        end else begin
            act[C_RD] = in_stb && is_read;
            act[C_WR] = in_stb && !is_read;
        end
    end

    // per-signal polarity
    for (genvar i = 0; i < NCTL; i++) begin : g_pol
        assign ctl_lvl[i] = to_level(act, pol)[i];
    end

    assign bus_oe = act[C_ALO] || act[C_AHI] || wr_data;

    always_comb begin
        if (act[C_ALO])      bus_out = addr[BYTE_W-1:0];
        else if (act[C_AHI]) bus_out = BYTE_W'(addr[ADDR_W-1:BYTE_W]);
        else if (wr_data)    bus_out = wr_q;
        else                 bus_out = '0;
    end

    always_comb begin
        if (amode == AM_FULL)      addr_pins = '0;
        else if (amode == AM_PART) addr_pins = {addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
        else if (use_cs)           addr_pins = {1'b0, addr[ADDR_W-2:0]};
        else                       addr_pins = addr;
    end

    if (HI_W < 1) begin : g_bad_width
        initial $display("pbus_pins: ADDR_W must exceed BYTE_W");
    end
endmodule

// File: rtl/pbus_master.sv
module pbus_master
    import pbus_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_amode,
    input  logic              cfg_strobe,
    input  logic [NCTL-1:0]   cfg_pol,
    input  logic [1:0]        cfg_auto,
    input  logic              cfg_use_cs,
    input  logic [WAIT_W-1:0] cfg_wait_setup,
    input  logic [WAIT_W-1:0] cfg_wait_strobe,
    input  logic [WAIT_W-1:0] cfg_wait_hold,
    input  logic              addr_ld,
    input  logic [ADDR_W-1:0] addr_ld_val,
    input  logic              start_rd,
    input  logic              start_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              busy,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_done,
    input  logic [BYTE_W-1:0] bus_in,
    output logic [BYTE_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] addr_pins,
    output logic              cs_pin,
    output logic              rd_pin,
    output logic              wr_pin,
    output logic              en_pin,
    output logic              alo_pin,
    output logic              ahi_pin
);
    phase_e            phase;
    logic              is_read, strb_end, txn_end, idle, go_rd, go_wr;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] wr_q;
    logic [NCTL-1:0]   ctl_lvl;

    assign idle  = (phase == PH_IDLE);
    assign go_rd = idle && start_rd;
    assign go_wr = idle && start_wr && !start_rd;
    assign busy  = !idle;

    pbus_seq u_seq (
        .clk(clk), .rst(rst), .go_rd(go_rd), .go_wr(go_wr), .amode(cfg_amode),
        .w_setup(cfg_wait_setup), .w_strb(cfg_wait_strobe), .w_hold(cfg_wait_hold),
        .phase(phase), .is_read(is_read), .strb_end(strb_end), .txn_end(txn_end)
    );

    pbus_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst(rst), .idle(idle), .ld(addr_ld), .ld_val(addr_ld_val),
        .txn_end(txn_end), .auto_mode(cfg_auto), .addr(addr)
    );

    pbus_pins #(.ADDR_W(ADDR_W)) u_pins (
        .phase(phase), .is_read(is_read), .addr(addr), .wr_q(wr_q),
        .amode(cfg_amode), .strobe_style(cfg_strobe), .use_cs(cfg_use_cs),
        .pol(cfg_pol), .bus_out(bus_out), .bus_oe(bus_oe),
        .addr_pins(addr_pins), .ctl_lvl(ctl_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= '0;
            rd_data <= '0;
            rd_done <= 1'b0;
        end else begin
            if (go_wr) wr_q <= wdata;
            if (strb_end && is_read) rd_data <= bus_in;
            if (go_rd || go_wr) rd_done <= 1'b0;
            else if (txn_end && is_read) rd_done <= 1'b1;
        end
    end

    assign cs_pin  = ctl_lvl[C_CS];
    assign rd_pin  = ctl_lvl[C_RD];
    assign wr_pin  = ctl_lvl[C_WR];
    assign en_pin  = ctl_lvl[C_EN];
    assign alo_pin = ctl_lvl[C_ALO];
    assign ahi_pin = ctl_lvl[C_AHI];
endmodule

// File: rtl/pbus_master_chk.sv
module pbus_master_chk
    import pbus_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [NCTL-1:0] cfg_pol,
    input logic            cfg_strobe,
    input logic            cfg_use_cs,
    input logic            busy,
    input logic            rd_done,
    input logic            bus_oe,
    input logic            cs_pin,
    input logic            rd_pin,
    input logic            wr_pin,
    input logic            en_pin,
    input logic            alo_pin,
    input logic            ahi_pin
);
    logic a_cs, a_rd, a_wr, a_en, a_alo, a_ahi, rd_strobe;

    assign a_cs  = cs_pin  ~^ cfg_pol[C_CS];
    assign a_rd  = rd_pin  ~^ cfg_pol[C_RD];
    assign a_wr  = wr_pin  ~^ cfg_pol[C_WR];
    assign a_en  = en_pin  ~^ cfg_pol[C_EN];
    assign a_alo = alo_pin ~^ cfg_pol[C_ALO];
    assign a_ahi = ahi_pin ~^ cfg_pol[C_AHI];
    assign rd_strobe = cfg_strobe ? (a_en && a_rd) : a_rd;

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_oe && !a_cs && !a_rd && !a_wr && !a_en && !a_alo && !a_ahi);

    a_r2_latch_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({a_alo, a_ahi}));

    a_r5_cs_while_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_use_cs) |-> a_cs);

    a_r6_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !cfg_strobe |-> $onehot0({a_rd, a_wr}));

    a_r9_no_contention: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |-> !bus_oe);

    a_r9_turnaround: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_strobe) |-> !$past(bus_oe));

    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        busy |-> !rd_done);
endmodule

bind pbus_master pbus_master_chk u_chk (
    .clk(clk), .rst(rst), .cfg_pol(cfg_pol), .cfg_strobe(cfg_strobe),
    .cfg_use_cs(cfg_use_cs), .busy(busy), .rd_done(rd_done), .bus_oe(bus_oe),
    .cs_pin(cs_pin), .rd_pin(rd_pin), .wr_pin(wr_pin), .en_pin(en_pin),
    .alo_pin(alo_pin), .ahi_pin(ahi_pin)
);

// File: tb/sim_pbus_master.sv
module sim_pbus_master;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cfg_amode = 2'd0;
    logic          cfg_strobe = 1'b0;
    logic [5:0]    cfg_pol = 6'd0;
    logic [1:0]    cfg_auto = 2'd0;
    logic          cfg_use_cs = 1'b1;
    logic [1:0]    ws = 2'd0, wst = 2'd0, wh = 2'd0;
    logic          addr_ld = 1'b0;
    logic [AW-1:0] addr_ld_val = '0;
    logic          start_rd = 1'b0, start_wr = 1'b0;
    logic [7:0]    wdata = 8'h00;
    logic          busy, rd_done, bus_oe;
    logic [7:0]    rd_data, bus_in, bus_out;
    logic [AW-1:0] addr_pins;
    logic          cs_pin, rd_pin, wr_pin, en_pin, alo_pin, ahi_pin;
    logic [7:0]    dev_byte = 8'h00;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pbus_master #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .cfg_amode(cfg_amode), .cfg_strobe(cfg_strobe),
        .cfg_pol(cfg_pol), .cfg_auto(cfg_auto), .cfg_use_cs(cfg_use_cs),
        .cfg_wait_setup(ws), .cfg_wait_strobe(wst), .cfg_wait_hold(wh),
        .addr_ld(addr_ld), .addr_ld_val(addr_ld_val), .start_rd(start_rd),
        .start_wr(start_wr), .wdata(wdata), .busy(busy), .rd_data(rd_data),
        .rd_done(rd_done), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .addr_pins(addr_pins), .cs_pin(cs_pin), .rd_pin(rd_pin), .wr_pin(wr_pin),
        .en_pin(en_pin), .alo_pin(alo_pin), .ahi_pin(ahi_pin)
    );

    wire a_cs  = cs_pin  ~^ cfg_pol[0];
    wire a_rd  = rd_pin  ~^ cfg_pol[1];
    wire a_wr  = wr_pin  ~^ cfg_pol[2];
    wire a_en  = en_pin  ~^ cfg_pol[3];
    wire a_alo = alo_pin ~^ cfg_pol[4];
    wire a_ahi = ahi_pin ~^ cfg_pol[5];
    wire dev_drive = cfg_strobe ? (a_en && a_rd) : a_rd;
    assign bus_in = dev_drive ? dev_byte : 8'h00;

    // per-transfer observations
    int n_busy, n_cs, n_rd, n_wr, n_en, n_alo, n_ahi;
    bit bad_alo, bad_ahi, bad_wr, clash, bad_turn, bad_apin, seen_rd, prev_oe;

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic load_addr(input logic [AW-1:0] v);
        @(negedge clk); addr_ld = 1'b1; addr_ld_val = v;
        @(negedge clk); addr_ld = 1'b0;
    endtask

    // run one transfer; apin_exp checked every busy cycle
    task automatic run_txn(input bit rd, input bit both, input logic [7:0] wd,
                           input logic [AW-1:0] a, input logic [AW-1:0] apin_exp);
        n_busy = 0; n_cs = 0; n_rd = 0; n_wr = 0; n_en = 0; n_alo = 0; n_ahi = 0;
        bad_alo = 0; bad_ahi = 0; bad_wr = 0; clash = 0; bad_turn = 0;
        bad_apin = 0; seen_rd = 0; prev_oe = 1;
        @(negedge clk);
        start_rd = rd || both; start_wr = !rd || both; wdata = wd;
        @(negedge clk);
        start_rd = 0; start_wr = 0;
        while (busy && n_busy < 100) begin
            n_busy++;
            if (a_cs)  n_cs++;
            if (a_rd)  n_rd++;
            if (a_wr)  n_wr++;
            if (a_en)  n_en++;
            if (a_alo) begin n_alo++; if (!bus_oe || bus_out != a[7:0]) bad_alo = 1; end
            if (a_ahi) begin n_ahi++; if (!bus_oe || bus_out != 8'(a[AW-1:8])) bad_ahi = 1; end
            if ((cfg_strobe ? a_en : a_wr) && !rd && (!bus_oe || bus_out != wd)) bad_wr = 1;
            if (dev_drive && bus_oe) clash = 1;
            if (dev_drive && !seen_rd) begin seen_rd = 1; if (prev_oe) bad_turn = 1; end
            if (addr_pins != apin_exp) bad_apin = 1;
            prev_oe = bus_oe;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R1", "busy", busy, 0);
        chk("R1", "rd_done", rd_done, 0);
        chk("R1", "bus_oe", bus_oe, 0);
        chk("R1", "pins idle", {ahi_pin, alo_pin, en_pin, wr_pin, rd_pin, cs_pin}, 6'h3f);
        chk("R1", "address zero on pins", addr_pins, 0);
    endtask

    task automatic t_polarity;
        cfg_pol = 6'b010101;
        #1;
        chk("R7", "mixed idle levels", {ahi_pin, alo_pin, en_pin, wr_pin, rd_pin, cs_pin}, 6'b101010);
        cfg_pol = 6'd0;
    endtask

    task automatic t_full_read;
        cfg_amode = 0; cfg_strobe = 0; cfg_use_cs = 1; cfg_auto = 1;
        ws = 1; wst = 2; wh = 1; dev_byte = 8'hC3;
        load_addr(12'h3A5);
        run_txn(1, 0, 8'h00, 12'h3A5, 12'h000);
        chk("R8", "full read busy cycles", n_busy, 10);
        chk("R2", "low latch cycles", n_alo, 2);
        chk("R2", "high latch cycles", n_ahi, 2);
        chk("R2", "latch bus contents", {bad_alo, bad_ahi}, 0);
        chk("R5", "cs cycles", n_cs, 10);
        chk("R6", "read strobe cycles", n_rd, 3);
        chk("R6", "write strobe idle", n_wr, 0);
        chk("R9", "turnaround and no clash", {bad_turn, clash}, 0);
        chk("R10", "rd_data", rd_data, 8'hC3);
        chk("R10", "rd_done", rd_done, 1);
    endtask

    task automatic t_part_write;
        cfg_amode = 1; ws = 0; wst = 0; wh = 2;
        run_txn(0, 0, 8'h5E, 12'h3A6, 12'h300);
        chk("R8", "partial write busy cycles", n_busy, 5);
        chk("R3", "single low latch", n_alo, 1);
        chk("R3", "no high latch", n_ahi, 0);
        chk("R11", "incremented low byte on bus", bad_alo, 0);
        chk("R3", "upper address pins", bad_apin, 0);
        chk("R6", "write strobe cycles", n_wr, 1);
        chk("R9", "write data driven", bad_wr, 0);
        chk("R10", "rd_done cleared by write", rd_done, 0);
    endtask

    task automatic t_demux_dir;
        cfg_amode = 2; cfg_strobe = 1; cfg_pol = 6'h3f; cfg_auto = 2;
        ws = 3; wst = 0; wh = 0; dev_byte = 8'h96;
        load_addr(12'hA5C);
        #1;
        chk("R7", "active-high idle levels", {ahi_pin, alo_pin, en_pin, wr_pin, rd_pin, cs_pin}, 6'h00);
        run_txn(1, 0, 8'h00, 12'hA5C, 12'h25C);
        chk("R8", "demux read busy cycles", n_busy, 3);
        chk("R4", "top pin zero with cs", bad_apin, 0);
        chk("R4", "no latches", n_alo + n_ahi, 0);
        chk("R6", "direction line cycles", n_rd, 3);
        chk("R6", "enable cycles", n_en, 1);
        chk("R6", "wr pin unused", n_wr, 0);
        chk("R5", "cs active-high cycles", n_cs, 3);
        chk("R9", "turnaround", {bad_turn, clash}, 0);
        chk("R10", "rd_data dir style", rd_data, 8'h96);
    endtask

    task automatic t_demux_nocs;
        cfg_strobe = 0; cfg_pol = 6'd0; cfg_use_cs = 0; cfg_auto = 2;
        wst = 1; wh = 0;
        @(negedge clk);
        chk("R11", "decrement after dir read", addr_pins, 12'hA5B);
        load_addr(12'h000);
        run_txn(0, 0, 8'h11, 12'h000, 12'h000);
        chk("R8", "demux write busy cycles", n_busy, 3);
        chk("R4", "cs stays off", n_cs, 0);
        chk("R4", "full address on pins", bad_apin, 0);
        chk("R11", "decrement wraps", addr_pins, 12'hFFF);
    endtask

    task automatic t_ignore;
        int guard = 0;
        bit saw_wr = 0;
        cfg_auto = 1; wst = 2; wh = 2;
        @(negedge clk); start_rd = 1;
        @(negedge clk); start_rd = 0;
        @(negedge clk); start_wr = 1; addr_ld = 1; addr_ld_val = 12'h123;
        @(negedge clk); start_wr = 0; addr_ld = 0;
        while (busy && guard < 100) begin
            guard++;
            if (a_wr) saw_wr = 1;
            @(negedge clk);
        end
        chk("R12", "no write strobe from busy request", saw_wr, 0);
        chk("R12", "load ignored, increment wraps (R11)", addr_pins, 12'h000);
        chk("R12", "read completed", rd_done, 1);
        @(negedge clk);
        chk("R12", "no delayed start", busy, 0);
        cfg_auto = 0;
        run_txn(1, 1, 8'h77, 12'h000, 12'h000);
        chk("R12", "read wins over write", {n_wr[0], rd_done}, 2'b01);
        chk("R11", "hold mode keeps address", addr_pins, 12'h000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_polarity();
        t_full_read();
        t_part_write();
        t_demux_dir();
        t_demux_nocs();
        t_ignore();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule